// File: doc/BRIEF.md
# Parallel Pipelined Sobel Edge Mapper

This block turns one 3x3 neighbourhood of 8-bit grey pixels per clock into a gradient magnitude and a one-bit edge decision. Two identical processing lanes run side by side. One lane forms the horizontal Sobel component and the other the vertical one. Each lane is split into short registered steps, and no step chains more than one two-input adder. The lanes' absolute values are summed. The sum is then compared with a threshold supplied on a port, which gives the edge flag.

An upstream window buffer presents the nine pixels together with a valid strobe. A new window may arrive on every clock, and gaps in the stream are allowed. Results come out in arrival order with a fixed latency. Each result carries its own valid strobe, so bubbles and back-to-back runs pass through unchanged. The result is the same as a single shared lane that computes both components in turn for the same window.

Top module: `sobel_edge_mapper`

## Requirements
- R1: For a valid window, with pixel (row r, column c) at bits [(3r+c)*8 +: 8] of the window bus and r, c counted from 0 at the top left, grad equals |Gx| + |Gy|. Gx = (p02-p00) + 2(p12-p10) + (p22-p20). Gy = (p20-p00) + 2(p21-p01) + (p22-p02).
- R2: edgeFlag is 1 exactly when grad is strictly greater than the threshold; a threshold equal to grad gives 0.
- R3: outValid is asserted exactly five clocks after inValid was sampled high, and it carries that window's result.
- R4: A window may be accepted on every clock; an unbroken run of valid windows yields an unbroken run of results.
- R5: The threshold is sampled four clocks after its window, on the same edge that registers the result. A threshold change takes effect for the window that reaches the comparator on that edge.
- R6: Synchronous reset clears every pipeline valid bit. Windows in flight while reset is sampled never produce a result.
- R7: A cycle with inValid low produces no result five clocks later, whatever the pixel inputs hold.
- R8: Any window, including all-0, all-255 and full-scale steps, gives a result without wrap; grad never exceeds 2040.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Window on winPix is valid this cycle |
| winPix | input | 72 | Nine 8-bit pixels, row-major, top-left at the low end |
| thr | input | 11 | Edge threshold |
| grad | output | 11 | Gradient magnitude |Gx|+|Gy| |
| edgeFlag | output | 1 | grad > thr |
| outValid | output | 1 | grad and edgeFlag hold a result |

## Verification
The hardest case to reach from the ports is a threshold that changes while a run of windows is in flight. A check that only uses a steady threshold would miss a comparator that samples it on the wrong edge. The stimulus therefore holds one full-scale step window for a stretch of cycles while the threshold alternates, every clock, between the gradient value and one below it. Only the correct sampling edge gives the expected alternating edge pattern. A reset pulse in the middle of a dense random stream checks that windows in flight are dropped. Directed extreme windows cover both the largest gradients and the strict-compare boundary.

// File: rtl/sobel_edge_pkg.sv
package sobel_edge_pkg;
  // stage count from window sampling to registered edge decision
  localparam int STAGES = 5;

  typedef struct packed {
    logic [STAGES-1:0] load;  // load[k]: stage k+1 captures on this edge
  } pipe_ctrl_t;
endpackage

// File: rtl/sobel_edge_ctrl.sv
module sobel_edge_ctrl
  import sobel_edge_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output pipe_ctrl_t ctl,
  output logic       outValid
);
  logic [STAGES-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[STAGES-2:0], inValid};
  end

  always_comb begin
    ctl.load = {vld[STAGES-2:0], inValid};
  end

  assign outValid = vld[STAGES-1];

  AST_LATENCY_MATCH: assert property (@(posedge clk) disable iff (rst) outValid |-> $past(inValid, 5)); // R3
  AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> !outValid); // R6
endmodule

// File: rtl/sobel_grad_pe.sv
module sobel_grad_pe
  import sobel_edge_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pipe_ctrl_t           ctl,
  input  logic [3*PIX_W-1:0]   aVec,
  input  logic [3*PIX_W-1:0]   bVec,
  output logic [PIX_W+1:0]     absQ
);
  localparam int DW = PIX_W + 1;             // one difference
  localparam int AW = PIX_W + 2;             // magnitude
  localparam int MAXABS = 4 * ((1 << PIX_W) - 1);

  logic signed [DW-1:0] diffQ [3];
  logic signed [DW:0]   outerQ;
  logic signed [DW:0]   midQ;
  logic signed [DW+1:0] sumC;
  logic        [DW+1:0] magC;

  // stage 1: three independent differences
  always_ff @(posedge clk) begin
    if (ctl.load[0]) begin
      for (int i = 0; i < 3; i++) begin
        diffQ[i] <= $signed({1'b0, aVec[i*PIX_W +: PIX_W]}) - $signed({1'b0, bVec[i*PIX_W +: PIX_W]});
      end
    end
  end

  // stage 2: outer pair summed, centre weighted by wiring
  always_ff @(posedge clk) begin
    if (ctl.load[1]) begin
      outerQ <= (DW+1)'(diffQ[0]) + (DW+1)'(diffQ[2]);
      midQ   <= {diffQ[1], 1'b0};
    end
  end

  // stage 3: combine and take magnitude
  always_comb begin
    sumC = (DW+2)'(outerQ) + (DW+2)'(midQ);
    magC = sumC[DW+1] ? $unsigned(-sumC) : $unsigned(sumC);
  end

  always_ff @(posedge clk) begin
    if (ctl.load[2]) absQ <= magC[AW-1:0];
  end

  AST_LANE_BOUND: assert property (@(posedge clk) disable iff (rst) ctl.load[3] |-> (32'(absQ) <= MAXABS)); // R8
endmodule

// File: rtl/sobel_edge_dp.sv
module sobel_edge_dp
  import sobel_edge_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pipe_ctrl_t           ctl,
  input  logic [9*PIX_W-1:0]   winPix,
  input  logic [PIX_W+2:0]     thr,
  output logic [PIX_W+2:0]     grad,
  output logic                 edgeFlag
);
  localparam int AW = PIX_W + 2;
  localparam int GW = PIX_W + 3;
  localparam int MAXGRAD = 8 * ((1 << PIX_W) - 1);

  logic [AW-1:0] laneAbs [2];
  logic [GW-1:0] sum4Q;
  logic [GW-1:0] gradQ;
  logic          edgeQ;

  // lane 0: horizontal (right column minus left), lane 1: vertical (bottom row minus top)
  for (genvar d = 0; d < 2; d++) begin : g_lane
    logic [3*PIX_W-1:0] aSel;
    logic [3*PIX_W-1:0] bSel;
    for (genvar i = 0; i < 3; i++) begin : g_tap
      localparam int AI = (d == 0) ? (3*i + 2) : (6 + i);
      localparam int BI = (d == 0) ? (3*i)     : i;
      assign aSel[i*PIX_W +: PIX_W] = winPix[AI*PIX_W +: PIX_W];
      assign bSel[i*PIX_W +: PIX_W] = winPix[BI*PIX_W +: PIX_W];
    end
    sobel_grad_pe #(.PIX_W(PIX_W)) u_pe (
      .clk (clk),
      .rst (rst),
      .ctl (ctl),
      .aVec(aSel),
      .bVec(bSel),
      .absQ(laneAbs[d])
    );
  end

  // stage 4: join the lanes
  always_ff @(posedge clk) begin
    if (ctl.load[3]) sum4Q <= GW'(laneAbs[0]) + GW'(laneAbs[1]);
  end

  // stage 5: registered compare
  always_ff @(posedge clk) begin
    if (ctl.load[4]) begin
      gradQ <= sum4Q;
      edgeQ <= (sum4Q > thr);
    end
  end

  assign grad     = gradQ;
  assign edgeFlag = edgeQ;

  AST_STRICT_COMPARE: assert property (@(posedge clk) disable iff (rst) ctl.load[4] |=> (edgeQ == (gradQ > $past(thr)))); // R2
  AST_GRAD_RANGE: assert property (@(posedge clk) disable iff (rst) ctl.load[4] |=> (32'(gradQ) <= MAXGRAD)); // R8
endmodule

// File: rtl/sobel_edge_mapper.sv
module sobel_edge_mapper
  import sobel_edge_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [9*PIX_W-1:0]   winPix,
  input  logic [PIX_W+2:0]     thr,
  output logic [PIX_W+2:0]     grad,
  output logic                 edgeFlag,
  output logic                 outValid
);
  pipe_ctrl_t ctl;

  sobel_edge_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .ctl     (ctl),
    .outValid(outValid)
  );

  sobel_edge_dp #(.PIX_W(PIX_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .winPix  (winPix),
    .thr     (thr),
    .grad    (grad),
    .edgeFlag(edgeFlag)
  );
endmodule

// File: tb/sobel_edge_mapper_bench.sv
module sobel_edge_mapper_bench;
  localparam int CLK_P = 10;
  localparam int N = 520;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [71:0] winPix = '0;
  logic [10:0] thr = '0;
  logic [10:0] grad;
  logic        edgeFlag;
  logic        outValid;

  int tests = 0;
  int fails = 0;

  logic [71:0] wArr [N];
  logic        vArr [N];
  logic        rArr [N];
  logic [10:0] tArr [N];
  string       segArr [N];

  always #(CLK_P/2) clk = ~clk;

  sobel_edge_mapper u_sobel_edge_mapper (
    .clk(clk), .rst(rst), .inValid(inValid), .winPix(winPix), .thr(thr),
    .grad(grad), .edgeFlag(edgeFlag), .outValid(outValid)
  );

  function automatic int px(logic [71:0] w, int r, int c);
    return int'(w[(3*r+c)*8 +: 8]);
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int model(logic [71:0] w);
    int gx, gy;
    gx = (px(w,0,2)-px(w,0,0)) + 2*(px(w,1,2)-px(w,1,0)) + (px(w,2,2)-px(w,2,0));
    gy = (px(w,2,0)-px(w,0,0)) + 2*(px(w,2,1)-px(w,0,1)) + (px(w,2,2)-px(w,0,2));
    return iabs(gx) + iabs(gy);
  endfunction

  function automatic logic [71:0] mkWin(int kind);
    logic [71:0] w;
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 3; c++) begin
        logic on;
        case (kind)
          0: on = 1'b0;
          1: on = 1'b1;
          2: on = (c == 2);
          3: on = (r == 2);
          4: on = (c == 2) || (r == 2);
          5: on = ((r + c) % 2) == 1;
          6: on = (c == 0);
          default: on = (r == 1) && (c == 1);
        endcase
        w[(3*r+c)*8 +: 8] = on ? 8'hFF : 8'h00;
      end
    end
    return w;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    // random background for every cycle
    for (int c = 0; c < N; c++) begin
      wArr[c]   = {$urandom(32'd7), $urandom, $urandom};
      vArr[c]   = 1'b1;
      rArr[c]   = 1'b0;
      tArr[c]   = 11'($urandom % 1700);
      segArr[c] = "R3";
    end
    for (int c = 0; c < 4; c++) begin
      rArr[c] = 1'b1; vArr[c] = 1'b0; segArr[c] = "R6";
    end
    // directed extremes and strict boundary: threshold equal or one below
    for (int t = 4; t < 12; t++) begin
      int g;
      wArr[t] = mkWin(t - 4);
      g = model(wArr[t]);
      tArr[t+4] = 11'((g == 0) ? 0 : g - (t % 2));
      segArr[t] = "R8";
    end
    // threshold sweep on a fixed full-scale step
    for (int t = 12; t < 28; t++) begin
      wArr[t] = mkWin(2);
      tArr[t+4] = 11'(model(wArr[t]) - (t % 2));
      segArr[t] = "R5";
    end
    for (int t = 28; t < 228; t++) segArr[t] = "R4";
    for (int t = 228; t < 428; t++) begin
      vArr[t] = 1'($urandom % 2);
      segArr[t] = "R7";
    end
    for (int t = 428; t < N; t++) vArr[t] = 1'($urandom % 4 != 0);
    rArr[300] = 1'b1;
    rArr[301] = 1'b1;

    for (int c = 0; c < N; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        int t;
        logic hit;
        logic expV;
        string vt;
        t = c - LAT;
        hit = 1'b0;
        for (int k = t; k < t + LAT; k++) hit |= rArr[k];
        expV = vArr[t] && !hit;
        if (hit) vt = "R6";
        else if (segArr[t] == "R4" || segArr[t] == "R7") vt = segArr[t];
        else vt = "R3";
        check(vt, int'(outValid), int'(expV));
        if (expV) begin
          int g;
          g = model(wArr[t]);
          check((segArr[t] == "R8") ? "R8" : "R1", int'(grad), g);
          check((segArr[t] == "R5") ? "R5" : "R2", int'(edgeFlag), int'(g > int'(tArr[c-1])));
        end
      end
      rst     = rArr[c];
      inValid = vArr[c];
      winPix  = wArr[c];
      thr     = tArr[c];
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule